// File: doc/BRIEF.md
# Discriminator Frame Link Receiver

This block sits behind four serial discriminator links, after their serial-to-parallel stage. On every word clock each link hands it twenty data bits and one framing strobe. The strobe marks the first of seven words that together carry one beam crossing. Each link has its own framing lock. Once all four links are locked and their strobes agree, the block collects the seven words of a crossing and rearranges the ten-bit slices of each word into a 512-bit record, one bit per channel over eight modules of 64 channels.

Each finished record goes into a show-ahead FIFO, stamped with a running crossing number. A drain interface downstream pops the records. When the FIFO is full, the whole crossing is discarded and an overflow counter records the loss. A sticky flag reports any word on which the locked links disagree about framing.

Top module: `frl_rx`

## Requirements
- R1: After reset, `link_lock` is 0, `rd_valid` is 0, `misalign` is 0 and `ovf_cnt` is 0.
- R2: A link becomes locked after three strobes in a row, each spaced exactly seven words from the one before. The lock bit is visible from the cycle after the third strobe is captured. Until then no crossing is recorded.
- R3: A locked link expects a strobe every seventh word. A strobe missing on the expected word counts as one error, and a strobe on any other word counts as one error. Two errors in a row unlock the link, and the unlock is visible the cycle after the second error word. One error followed by a correctly placed strobe keeps the lock.
- R4: A crossing starts on a word where all links are locked and all strobes are set. That word is word 0, and the next six words complete the crossing. The record reaches the FIFO output two cycles after word 6 is captured.
- R5: Link l carries module 2l in data bits [9:0] and module 2l+1 in bits [19:10]. Channel c of module m is slice bit c mod 10 of word c/10, and lands in record bit m*64+c. Slice bits 4 to 9 of word 6 have no effect on the record.
- R6: `misalign` is set on any word where all links are locked and some strobes, but not all, are set. No crossing is recorded from that word. The flag stays set until reset.
- R7: Every completed crossing takes the current 16-bit crossing number, which starts at 0 after reset, and then increments the number. This includes crossings that are dropped. Crossings that are never started are not counted.
- R8: When a crossing completes while the FIFO is full, none of its bits are stored, `ovf_cnt` increments by one, and the entries already stored are unchanged.
- R9: `rd_valid` shows that the FIFO is non-empty, and `rd_chan`/`rd_xc` present the oldest entry. `rd_en` with `rd_valid` pops that entry, and entries leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lnk_data | input | 80 | Data bits, link l at [l*20 +: 20] |
| lnk_frame | input | 4 | Framing strobe, one per link |
| rd_en | input | 1 | Pop the oldest record |
| rd_valid | output | 1 | FIFO holds at least one record |
| rd_chan | output | 512 | Channel bits of the oldest record |
| rd_xc | output | 16 | Crossing number of the oldest record |
| link_lock | output | 4 | Per-link framing lock |
| misalign | output | 1 | Sticky strobe-disagreement flag |
| ovf_cnt | output | 16 | Crossings dropped on a full FIFO |

## Verification
The bench checks the exact cycle of lock and of unlock. A lock counter off by one would raise `link_lock` one crossing early or late, and a missing flywheel would drop lock on the first missing strobe. It sends a single lost strobe followed by a good one, where a design with a non-clearing error count would later lose lock on a single error. It delays one link's strobe by one word: a design that records anyway, or that fails to latch `misalign`, would put a shifted record into the FIFO. Six crossings into a four-entry FIFO test the overflow path. A partial write would corrupt the stored records, and a crossing number that skips drops would give the next record the number 4 instead of 6.

// File: rtl/frl_pkg.sv
package frl_pkg;
   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_LOCK = 1'b1
   } lock_state_t;
endpackage

// File: rtl/frl_lock.sv
module frl_lock
   import frl_pkg::*;
#(
   parameter int WORDS     = 7,
   parameter int LOCK_HITS = 3,
   parameter int LOSS_ERRS = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic frame_i,
   output logic locked_o
);
   localparam int PW = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int HW = $clog2(LOCK_HITS + 1);
   localparam int EW = $clog2(LOSS_ERRS + 1);
   localparam logic [PW-1:0] LAST = PW'(WORDS - 1);

   if (WORDS < 2) begin : g_chk_words
      $error("frl_lock: WORDS must be at least 2");
   end
   if (LOCK_HITS < 2) begin : g_chk_hits
      $error("frl_lock: LOCK_HITS must be at least 2");
   end
   if (LOSS_ERRS < 1) begin : g_chk_errs
      $error("frl_lock: LOSS_ERRS must be at least 1");
   end

   lock_state_t   st;
   logic [PW-1:0] ph;
   logic [HW-1:0] hits;
   logic [EW-1:0] errs;
   logic          due;

   assign due = (ph == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_HUNT;
         ph   <= '0;
         hits <= '0;
         errs <= '0;
      end else if (st == ST_HUNT) begin
         if (frame_i) ph <= '0;
         else if (!due) ph <= ph + 1'b1;
         if (frame_i && due && (hits != '0)) begin
            if (hits == HW'(LOCK_HITS - 1)) begin
               st   <= ST_LOCK;
               hits <= '0;
               errs <= '0;
            end else begin
               hits <= hits + 1'b1;
            end
         end else if (frame_i) begin
            hits <= HW'(1);
         end else if (due) begin
            hits <= '0;
         end
      end else begin
         ph <= due ? '0 : ph + 1'b1;
         if (frame_i != due) begin
            if (errs == EW'(LOSS_ERRS - 1)) begin
               st   <= ST_HUNT;
               errs <= '0;
               hits <= '0;
            end else begin
               errs <= errs + 1'b1;
            end
         end else if (due) begin
            errs <= '0;
         end
      end
   end

   assign locked_o = (st == ST_LOCK);
endmodule

// File: rtl/frl_gather.sv
module frl_gather #(
   parameter int NLINK = 4,
   parameter int SLICE = 10,
   parameter int WORDS = 7,
   parameter int CH    = 64
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NLINK*2*SLICE-1:0] data_i,
   input  logic                     start_i,
   input  logic                     abort_i,
   output logic                     done_o,
   output logic [NLINK*2*CH-1:0]    rec_o
);
   localparam int NMOD  = NLINK * 2;
   localparam int WW    = NMOD * SLICE;
   localparam int WCW   = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int SPARE = WORDS * SLICE - CH;

   if (SPARE < 0) begin : g_chk_fit
      $error("frl_gather: WORDS*SLICE must cover CH");
   end

   logic [WW-1:0]  wbuf [WORDS];
   logic           active;
   logic [WCW-1:0] wc;
   logic           wr_en;
   logic [WCW-1:0] wr_idx;

   assign wr_en  = start_i || (active && !abort_i);
   assign wr_idx = start_i ? '0 : wc;

   always_ff @(posedge clk) begin
      if (wr_en) wbuf[wr_idx] <= data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         wc     <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            active <= 1'b1;
            wc     <= WCW'(1);
         end else if (active) begin
            if (abort_i) begin
               active <= 1'b0;
            end else if (wc == WCW'(WORDS - 1)) begin
               active <= 1'b0;
               done_o <= 1'b1;
            end else begin
               wc <= wc + 1'b1;
            end
         end
      end
   end

   for (genvar m = 0; m < NMOD; m++) begin : g_mod
      for (genvar c = 0; c < CH; c++) begin : g_ch
         assign rec_o[m*CH + c] = wbuf[c / SLICE][m*SLICE + (c % SLICE)];
      end
   end

   if (SPARE > 0) begin : g_spare
      logic [NMOD*SPARE-1:0] spare_unused_bits;
      logic                  spare_unused;
      for (genvar m = 0; m < NMOD; m++) begin : g_smod
         for (genvar p = CH; p < WORDS*SLICE; p++) begin : g_sbit
            assign spare_unused_bits[m*SPARE + p - CH] = wbuf[p / SLICE][m*SLICE + (p % SLICE)];
         end
      end
      assign spare_unused = ^spare_unused_bits;
   end
endmodule

// File: rtl/frl_fifo.sv
module frl_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_chk_depth
      $error("frl_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_wr, do_rd;

   assign do_wr = push && !full;
   assign do_rd = pop && !empty;

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_wr) wp <= wp + 1'b1;
         if (do_rd) rp <= rp + 1'b1;
         unique case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign dout  = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == (AW+1)'(DEPTH));
endmodule

// File: rtl/frl_rx.sv
module frl_rx
   import frl_pkg::*;
#(
   parameter int NLINK     = 4,
   parameter int SLICE     = 10,
   parameter int WORDS     = 7,
   parameter int CH        = 64,
   parameter int XC_W      = 16,
   parameter int OVF_W     = 16,
   parameter int DEPTH     = 4,
   parameter int LOCK_HITS = 3,
   parameter int LOSS_ERRS = 2
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NLINK*2*SLICE-1:0] lnk_data,
   input  logic [NLINK-1:0]         lnk_frame,
   input  logic                     rd_en,
   output logic                     rd_valid,
   output logic [NLINK*2*CH-1:0]    rd_chan,
   output logic [XC_W-1:0]          rd_xc,
   output logic [NLINK-1:0]         link_lock,
   output logic                     misalign,
   output logic [OVF_W-1:0]         ovf_cnt
);
   localparam int RW = NLINK * 2 * CH;
   localparam int EW = XC_W + RW;

   if (NLINK < 1) begin : g_chk_links
      $error("frl_rx: NLINK must be at least 1");
   end

   logic          all_lock, all_frame, any_frame, start;
   logic          rec_done, fifo_full, fifo_empty, push;
   logic [RW-1:0] rec;
   logic [XC_W-1:0] xc_q;
   logic [EW-1:0] fifo_q;

   for (genvar l = 0; l < NLINK; l++) begin : g_link
      frl_lock #(
         .WORDS     (WORDS),
         .LOCK_HITS (LOCK_HITS),
         .LOSS_ERRS (LOSS_ERRS)
      ) i_lock (
         .clk      (clk),
         .rst_n    (rst_n),
         .frame_i  (lnk_frame[l]),
         .locked_o (link_lock[l])
      );
   end

   assign all_lock  = &link_lock;
   assign all_frame = &lnk_frame;
   assign any_frame = |lnk_frame;
   assign start     = all_lock && all_frame;

   frl_gather #(
      .NLINK (NLINK),
      .SLICE (SLICE),
      .WORDS (WORDS),
      .CH    (CH)
   ) i_gather (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_i  (lnk_data),
      .start_i (start),
      .abort_i (!all_lock),
      .done_o  (rec_done),
      .rec_o   (rec)
   );

   assign push = rec_done && !fifo_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         misalign <= 1'b0;
         xc_q     <= '0;
         ovf_cnt  <= '0;
      end else begin
         if (all_lock && any_frame && !all_frame) misalign <= 1'b1;
         if (rec_done) xc_q <= xc_q + 1'b1;
         if (rec_done && fifo_full) ovf_cnt <= ovf_cnt + 1'b1;
      end
   end

   frl_fifo #(
      .W     (EW),
      .DEPTH (DEPTH)
   ) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   ({xc_q, rec}),
      .pop   (rd_en),
      .dout  (fifo_q),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   assign {rd_xc, rd_chan} = fifo_q;
   assign rd_valid         = !fifo_empty;
endmodule

// File: rtl/frl_rx_chk.sv
module frl_rx_chk #(
   parameter int NLINK = 4,
   parameter int XC_W  = 16,
   parameter int OVF_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic [NLINK-1:0] lnk_frame,
   input logic [NLINK-1:0] link_lock,
   input logic             misalign,
   input logic [OVF_W-1:0] ovf_cnt,
   input logic             rd_valid,
   input logic             rec_done,
   input logic             fifo_full,
   input logic [XC_W-1:0]  xc_q
);
   for (genvar l = 0; l < NLINK; l++) begin : g_lk
      AST_LOCK_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(link_lock[l]) |-> $past(lnk_frame[l])); // R2
   end

   AST_MISALIGN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (&link_lock && |lnk_frame && !(&lnk_frame)) |=> misalign); // R6

   AST_MISALIGN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |=> misalign); // R6

   AST_XC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rec_done |=> (xc_q == XC_W'($past(xc_q) + 1'b1))); // R7

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_done && fifo_full) |=> (ovf_cnt == OVF_W'($past(ovf_cnt) + 1'b1))); // R8

   AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rec_done |=> $stable(ovf_cnt)); // R8

   AST_FULL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> rd_valid); // R9
endmodule

bind frl_rx frl_rx_chk #(
   .NLINK (NLINK),
   .XC_W  (XC_W),
   .OVF_W (OVF_W)
) i_frl_rx_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lnk_frame (lnk_frame),
   .link_lock (link_lock),
   .misalign  (misalign),
   .ovf_cnt   (ovf_cnt),
   .rd_valid  (rd_valid),
   .rec_done  (rec_done),
   .fifo_full (fifo_full),
   .xc_q      (xc_q)
);

// File: tb/test_frl_rx.sv
`timescale 1ns/1ps
module test_frl_rx;
   localparam int NLINK = 4;
   localparam int SLICE = 10;
   localparam int WORDS = 7;
   localparam int CH    = 64;
   localparam int WL    = 2 * SLICE;
   localparam int WW    = NLINK * WL;
   localparam int RW    = NLINK * 2 * CH;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [WW-1:0]   lnk_data = '0;
   logic [NLINK-1:0] lnk_frame = '0;
   logic            rd_en = 1'b0;
   logic            rd_valid;
   logic [RW-1:0]   rd_chan;
   logic [15:0]     rd_xc;
   logic [NLINK-1:0] link_lock;
   logic            misalign;
   logic [15:0]     ovf_cnt;

   int checks = 0;
   int fails  = 0;
   int exp_xc = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   frl_rx i_frl_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .lnk_data  (lnk_data),
      .lnk_frame (lnk_frame),
      .rd_en     (rd_en),
      .rd_valid  (rd_valid),
      .rd_chan   (rd_chan),
      .rd_xc     (rd_xc),
      .link_lock (link_lock),
      .misalign  (misalign),
      .ovf_cnt   (ovf_cnt)
   );

   function automatic logic [WL-1:0] gen(input int seed, input int l, input int w);
      logic [31:0] x;
      x = 32'(seed) * 32'h9E3779B1 ^ (32'(l) * 32'h85EBCA6B) ^ (32'(w) * 32'hC2B2AE35);
      x = x ^ (x >> 15);
      x = x * 32'h2C1B3C6D;
      x = x ^ (x >> 13);
      return x[WL-1:0];
   endfunction

   function automatic logic [RW-1:0] exp_rec(input int seed);
      logic [RW-1:0] r;
      logic [WL-1:0] g;
      r = '0;
      for (int m = 0; m < NLINK*2; m++) begin
         for (int c = 0; c < CH; c++) begin
            g = gen(seed, m / 2, c / SLICE);
            r[m*CH + c] = g[(m % 2)*SLICE + (c % SLICE)];
         end
      end
      return r;
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive_word(input int seed, input int w, input logic [NLINK-1:0] fr);
      @(negedge clk);
      for (int l = 0; l < NLINK; l++) lnk_data[l*WL +: WL] = gen(seed, l, w);
      lnk_frame = fr;
   endtask

   task automatic send_crossing(input int seed, input logic [NLINK-1:0] f0, input logic [NLINK-1:0] f1);
      for (int w = 0; w < WORDS; w++)
         drive_word(seed, w, (w == 0) ? f0 : ((w == 1) ? f1 : '0));
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         lnk_data  = '0;
         lnk_frame = '0;
      end
   endtask

   task automatic relock();
      idle(20);
      chk("R3", "lock cleared after gap", 64'(link_lock), 64'(0));
      send_crossing(701, '1, '0);
      send_crossing(702, '1, '0);
      chk("R2", "no lock after two strobes", 64'(link_lock), 64'(0));
      send_crossing(703, '1, '0);
      chk("R2", "lock after third strobe", 64'(link_lock), 64'({NLINK{1'b1}}));
   endtask

   task automatic pop_check(input int seed, input int xc, input string req);
      @(negedge clk);
      chk(req, "rd_valid before pop", 64'(rd_valid), 64'(1));
      checks++;
      if (rd_chan !== exp_rec(seed)) begin
         fails++;
         $display("FAIL %s record seed %0d: actual=%0h expected=%0h", req, seed, rd_chan, exp_rec(seed));
      end
      chk(req, "crossing number", 64'(rd_xc), 64'(xc));
      rd_en = 1'b1;
      @(posedge clk);
      #1 rd_en = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1", "lock at reset", 64'(link_lock), 64'(0));
      chk("R1", "rd_valid at reset", 64'(rd_valid), 64'(0));
      chk("R1", "misalign at reset", 64'(misalign), 64'(0));
      chk("R1", "ovf_cnt at reset", 64'(ovf_cnt), 64'(0));
      rst_n = 1'b1;
   endtask

   task automatic t_lock_data();
      relock();
      chk("R4", "no record before lock", 64'(rd_valid), 64'(0));
      send_crossing(11, '1, '0);
      send_crossing(12, '1, '0);
      send_crossing(13, '1, '0);
      idle(7);
      @(negedge clk);
      chk("R3", "lock held after one missing strobe", 64'(link_lock), 64'({NLINK{1'b1}}));
      @(negedge clk);
      chk("R3", "unlock after second missing strobe", 64'(link_lock), 64'(0));
      // R5: the spare slice bits of word 6 differ between seeds and are absent from exp_rec
      pop_check(11, exp_xc, "R5");
      pop_check(12, exp_xc + 1, "R9");
      pop_check(13, exp_xc + 2, "R7");
      exp_xc += 3;
      @(negedge clk);
      chk("R9", "empty after drain", 64'(rd_valid), 64'(0));
   endtask

   task automatic t_single_error();
      relock();
      send_crossing(21, '1, '0);
      send_crossing(22, '0, '0);
      send_crossing(23, '1, '0);
      chk("R3", "single error tolerated", 64'(link_lock), 64'({NLINK{1'b1}}));
      idle(20);
      pop_check(21, exp_xc, "R4");
      pop_check(23, exp_xc + 1, "R4");
      exp_xc += 2;
      @(negedge clk);
      chk("R4", "strobeless crossing not recorded", 64'(rd_valid), 64'(0));
   endtask

   task automatic t_misalign();
      relock();
      chk("R6", "misalign clear while aligned", 64'(misalign), 64'(0));
      send_crossing(31, 4'b1011, 4'b0100);
      chk("R6", "misalign set", 64'(misalign), 64'(1));
      chk("R3", "late link unlocked", 64'(link_lock), 64'(4'b1011));
      idle(20);
      chk("R6", "misaligned crossing not recorded", 64'(rd_valid), 64'(0));
      chk("R6", "misalign sticky", 64'(misalign), 64'(1));
   endtask

   task automatic t_overflow();
      relock();
      for (int k = 0; k < 6; k++) send_crossing(41 + k, '1, '0);
      idle(20);
      chk("R8", "two crossings dropped", 64'(ovf_cnt), 64'(2));
      for (int k = 0; k < 4; k++) pop_check(41 + k, exp_xc + k, "R8");
      @(negedge clk);
      chk("R9", "empty after overflow drain", 64'(rd_valid), 64'(0));
      exp_xc += 6;
      relock();
      send_crossing(51, '1, '0);
      idle(20);
      pop_check(51, exp_xc, "R7");
      exp_xc += 1;
      chk("R8", "ovf_cnt unchanged without drop", 64'(ovf_cnt), 64'(2));
   endtask

   initial begin
      t_reset();
      t_lock_data();
      t_single_error();
      t_misalign();
      t_overflow();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule